// File: doc/BRIEF.md
# TDM Codec Serial Port

This block is the device end of a four-wire time-division-multiplexed serial link between a signal processor and a chain of audio codecs. The bus master supplies a serial clock and a frame pulse. From these the block works out which 16-bit slots belong to this device. Its place in the chain is set by `position`, and the chain length is given as `chain_last`, the number of devices minus one. In its own slots it shifts the ADC sample out and captures the DAC sample in. The serial clock is oversampled by the system clock `clk`. DOUT and its enable are updated on each serial-clock rising edge, and DIN is taken on each falling edge.

The port has two framing modes. In programming mode a frame holds N data slots followed by N control slots. A control word either writes an 8-bit register or asks for one to be read back. Setting the continuous-enable bit of the mode register moves the port to continuous mode, where a frame holds only the N data slots. The port can leave continuous mode in-band, through a data word with its LSB set, if the 15+1 format bit is set. Serial clocks that arrive after the last slot of a frame are ignored, so fast (turbo) clocking works with the frame pulse still at the sampling rate.

Top module: `tdm_codec_port`

## Requirements
- R1: After reset `dout_oe`, `dout`, `dac_valid` and `cont_mode` are 0, `dac_sample` is 0 and every register holds 0.
- R2: A frame's bit counter starts at the first SCLK rise after FS falls. Bit k of the frame lies in slot k/16. In programming mode the frame has 2N slots (N = `chain_last`+1). The device drives data slot `position` with the ADC sample latched at the FS fall, MSB first. `dout_oe` is high only in the device's own slots.
- R3: In programming mode, control slot N+`position` is received MSB first. Bit 15 = 0 marks a write, with bits 14:11 the address and bits 7:0 the data.
- R4: A control word with bit 15 = 1 reads the register at bits 14:11. In the next frame the device's control slot carries {8'h00, register}. Otherwise that slot carries 0.
- R5: The word received in the device's data slot appears on `dac_sample` with a one-cycle `dac_valid` pulse, once per frame.
- R6: SCLK cycles after the last slot of a frame neither drive DOUT nor capture DIN.
- R7: Writing 1 to bit 6 of register 1 (`cont_mode`) makes the following frames hold only N data slots and no control slots.
- R8: In continuous mode, a data word with LSB 1 clears register 1 bit 6 and returns to programming mode, but only when register 1 bit 0 is 1. With bit 0 clear the word is only passed to the DAC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock oversampling SCLK and FS |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial bit clock from the bus master |
| fs | input | 1 | Frame pulse; its falling edge starts a frame |
| din | input | 1 | Serial data from the processor |
| dout | output | 1 | Serial data to the processor |
| dout_oe | output | 1 | DOUT drive enable; low means DOUT is released |
| chain_last | input | 4 | Number of devices in the chain minus one |
| position | input | 4 | This device's index in the chain, 0 for the master |
| adc_sample | input | 16 | ADC word to transmit |
| dac_sample | output | 16 | Last DAC word received |
| dac_valid | output | 1 | One-cycle pulse when `dac_sample` updates |
| cont_mode | output | 1 | Register 1 bit 6: continuous mode requested |

## Verification
The hardest situation to reach is the in-band exit from continuous mode. It needs register 1 to be written with both the format and the continuous bits in an earlier programming frame. The next frame must then be clocked with only N slots, and a data word with LSB set must arrive in the device's own slot. The bench makes this sequence after a reset and checks that the following frame has control slots again. A read of register 1 through DOUT in the frame after that shows bit 6 cleared. The bench also sweeps every position in chains of one to four devices, with and without turbo tail cycles.

// File: rtl/tdm_codec_port.sv
module tdm_codec_port #(
  parameter int MAX_DEV = 16,
  parameter int SLOT_W  = 16,
  parameter int REG_AW  = 4,
  parameter int REG_DW  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk,
  input  logic                       fs,
  input  logic                       din,
  output logic                       dout,
  output logic                       dout_oe,
  input  logic [$clog2(MAX_DEV)-1:0] chain_last,
  input  logic [$clog2(MAX_DEV)-1:0] position,
  input  logic [SLOT_W-1:0]          adc_sample,
  output logic [SLOT_W-1:0]          dac_sample,
  output logic                       dac_valid,
  output logic                       cont_mode
);
  localparam int PW = $clog2(MAX_DEV);
  localparam int SW = $clog2(2 * MAX_DEV);
  localparam int BW = $clog2(SLOT_W);
  localparam int CW = SW + BW;
  localparam int NREG = 2 ** REG_AW;
  localparam int MODE_ADDR = 1;
  localparam int CONT_BIT = 6;
  localparam int FMT_BIT = 0;

  logic s1, s2, f1, f2;
  logic armed, active, mode_f, rd_pend;
  logic [CW-1:0] cnt;
  logic [SLOT_W-1:0] tx_data, tx_ctrl, rx_sh, dac_q;
  logic [REG_DW-1:0] regs [NREG];
  logic [REG_AW-1:0] rd_addr;
  logic dv;

  wire sck_rise = s1 & ~s2;
  wire sck_fall = ~s1 & s2;
  wire fs_fall  = ~f1 & f2;

  wire [SW-1:0] slot  = cnt[CW-1:BW];
  wire [BW-1:0] bit_i = cnt[BW-1:0];
  wire          fmt_on = regs[MODE_ADDR][FMT_BIT];

  wire [SW:0] ndev  = {{(SW+1-PW){1'b0}}, chain_last} + (SW+1)'(1);
  wire [SW:0] nsl   = mode_f ? ndev : (ndev << 1);
  wire [CW:0] fbits = {nsl, {BW{1'b0}}};
  wire [CW:0] lastw = fbits - (CW+1)'(1);

  wire in_chain = position <= chain_last;
  wire in_data  = active && in_chain && slot == SW'(position);
  wire in_ctrl  = active && in_chain && !mode_f &&
                  slot == SW'(chain_last) + SW'(position) + SW'(1);

  wire [SLOT_W-1:0] tx_word = in_ctrl ? tx_ctrl : tx_data;
  wire [SLOT_W-1:0] rx_word = {rx_sh[SLOT_W-2:0], din};

  assign dout_oe    = in_data | in_ctrl;
  assign dout       = dout_oe & tx_word[~bit_i];
  assign dac_sample = dac_q;
  assign dac_valid  = dv;
  assign cont_mode  = regs[MODE_ADDR][CONT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; f1 <= 1'b0; f2 <= 1'b0;
    end else begin
      s1 <= sclk; s2 <= s1; f1 <= fs; f2 <= f1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      active  <= 1'b0;
      mode_f  <= 1'b0;
      cnt     <= '0;
      tx_data <= '0;
      tx_ctrl <= '0;
      rx_sh   <= '0;
      dac_q   <= '0;
      dv      <= 1'b0;
      rd_pend <= 1'b0;
      rd_addr <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      dv <= 1'b0;
      if (fs_fall) begin
        armed   <= 1'b1;
        tx_data <= adc_sample;
        tx_ctrl <= rd_pend ? SLOT_W'(regs[rd_addr]) : '0;
        rd_pend <= 1'b0;
      end
      if (sck_rise) begin
        if (armed) begin
          armed  <= 1'b0;
          active <= 1'b1;
          cnt    <= '0;
          mode_f <= cont_mode;
        end else if (active) begin
          if (cnt == lastw[CW-1:0]) active <= 1'b0;
          else cnt <= cnt + CW'(1);
        end
      end
      if (sck_fall && (in_data || in_ctrl)) begin
        rx_sh <= rx_word;
        if (bit_i == BW'(SLOT_W - 1)) begin
          if (in_data) begin
            dac_q <= rx_word;
            dv    <= 1'b1;
            if (mode_f && fmt_on && rx_word[0])
              regs[MODE_ADDR][CONT_BIT] <= 1'b0;
          end else if (rx_word[SLOT_W-1]) begin
            rd_addr <= rx_word[SLOT_W-2 -: REG_AW];
            rd_pend <= 1'b1;
          end else begin
            regs[rx_word[SLOT_W-2 -: REG_AW]] <= rx_word[REG_DW-1:0];
          end
        end
      end
    end
  end
endmodule

// File: rtl/tdm_codec_port_chk.sv
module tdm_codec_port_chk #(
  parameter int SW = 5,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          active,
  input logic          mode_f,
  input logic          dout,
  input logic          dout_oe,
  input logic          dac_valid,
  input logic          cont_mode,
  input logic          fmt_on,
  input logic [SW-1:0] slot,
  input logic [PW-1:0] position,
  input logic          sck_rise,
  input logic          fs_fall
);
  // R1
  always @(posedge clk)
    if (!rst_n) reset_idle_chk: assert (!dout_oe && !dac_valid && !cont_mode);

  // R6
  oe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> active);

  // R2
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sck_rise) && !$past(fs_fall)) |-> $stable(dout));

  // R7
  cont_no_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && mode_f) |-> slot == SW'(position));

  // R5
  dac_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |=> !dac_valid);

  // R8
  cont_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cont_mode) |-> fmt_on);
endmodule

bind tdm_codec_port tdm_codec_port_chk #(.SW(SW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .mode_f(mode_f),
  .dout(dout), .dout_oe(dout_oe), .dac_valid(dac_valid),
  .cont_mode(cont_mode), .fmt_on(fmt_on), .slot(slot),
  .position(position), .sck_rise(sck_rise), .fs_fall(fs_fall)
);

// File: tb/tdm_codec_port_test.sv
module tdm_codec_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, fs = 1'b0, din = 1'b0;
  logic [3:0] chain_last = '0, position = '0;
  logic [15:0] adc_sample = '0;
  logic dout, dout_oe, dac_valid, cont_mode;
  logic [15:0] dac_sample;

  tdm_codec_port uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .fs(fs), .din(din),
    .dout(dout), .dout_oe(dout_oe), .chain_last(chain_last),
    .position(position), .adc_sample(adc_sample),
    .dac_sample(dac_sample), .dac_valid(dac_valid), .cont_mode(cont_mode)
  );

  always #4 clk = ~clk;

  int tests = 0, fails = 0, cycles = 0, dv_cnt = 0;
  logic [15:0] din_w [32];
  logic [15:0] got_w [32];
  int oe_n [32];
  int extra_oe;

  always @(posedge clk) begin
    cycles++;
    if (dac_valid) dv_cnt++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wr(input int a, input int d);
    return {1'b0, 4'(a), 3'b000, 8'(d)};
  endfunction

  function automatic logic [15:0] rd(input int a);
    return {1'b1, 4'(a), 11'b0};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_frame(input int nslots, input int extra);
    fs = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0; fs = 1'b0;
    repeat (4) @(negedge clk);
    for (int s = 0; s < 32; s++) begin got_w[s] = '0; oe_n[s] = 0; end
    extra_oe = 0;
    for (int b = 0; b < nslots * 16 + extra; b++) begin
      sclk = 1'b1;
      din = (b < nslots * 16) ? din_w[b / 16][15 - b % 16] : 1'b1;
      repeat (3) @(negedge clk);
      if (dout_oe) begin
        if (b < nslots * 16) begin
          oe_n[b / 16]++;
          got_w[b / 16][15 - b % 16] = dout;
        end else extra_oe++;
      end
      @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  function automatic int val(input int k, input int l);
    return (8'h5A ^ (k * 16 + l)) & 8'hFF;
  endfunction

  initial begin
    do_reset();
    // R1
    chk(!dout_oe && !dout, "R1 dout idle", int'(dout_oe), 0);
    chk(!cont_mode && !dac_valid, "R1 mode/valid", int'(cont_mode), 0);
    chk(dac_sample == 16'h0, "R1 dac", int'(dac_sample), 0);

    for (int l = 0; l < 4; l++) begin
      for (int p = 0; p <= l; p++) begin
        int n, ext, dv0, ok_oe;
        n = l + 1;
        ext = (l % 2 == 1) ? 20 : 0;
        chain_last = 4'(l); position = 4'(p);
        adc_sample = 16'(16'h1000 * p + 16'h0111 * l + 16'h0A05);
        for (int s = 0; s < n; s++) begin
          din_w[s] = 16'(16'hC300 + s * 16'h0101 + l);
          din_w[n + s] = wr(2 + s, val(s, l));
        end
        dv0 = dv_cnt;
        run_frame(2 * n, ext);
        repeat (4) @(negedge clk);
        ok_oe = 1;
        for (int s = 0; s < 2 * n; s++)
          if (oe_n[s] != ((s == p || s == n + p) ? 16 : 0)) ok_oe = 0;
        // R2
        chk(ok_oe == 1, "R2 slot ownership", oe_n[p], 16);
        chk(got_w[p] == adc_sample, "R2 adc word", int'(got_w[p]), int'(adc_sample));
        // R6
        chk(extra_oe == 0, "R6 tail ignored", extra_oe, 0);
        // R5
        chk(dac_sample == din_w[p] && dv_cnt - dv0 == 1, "R5 dac word",
            int'(dac_sample), int'(din_w[p]));
        // R4 no read pending
        chk(got_w[n + p] == 16'h0, "R4 idle ctrl slot", int'(got_w[n + p]), 0);

        for (int s = 0; s < n; s++) begin
          din_w[s] = 16'(16'h0F00 + s);
          din_w[n + s] = rd(2 + s);
        end
        run_frame(2 * n, ext);
        for (int s = 0; s < n; s++) din_w[n + s] = wr(15, 8'hEE);
        run_frame(2 * n, ext);
        repeat (4) @(negedge clk);
        // R3 R4
        chk(got_w[n + p] == 16'(val(p, l)), "R3/R4 readback",
            int'(got_w[n + p]), val(p, l));
        chk(dac_sample == 16'(16'h0F00 + p), "R5 dac frame3", int'(dac_sample), 16'h0F00 + p);
      end
    end

    // continuous mode, format bit clear
    do_reset();
    chain_last = 4'd2; position = 4'd1; adc_sample = 16'hBEEF;
    for (int s = 0; s < 6; s++) din_w[s] = 16'h0;
    din_w[4] = wr(1, 8'h40);
    run_frame(6, 0);
    repeat (4) @(negedge clk);
    // R7
    chk(cont_mode == 1'b1, "R7 enter", int'(cont_mode), 1);
    din_w[1] = 16'h1235;
    run_frame(3, 48);
    repeat (4) @(negedge clk);
    chk(oe_n[0] == 0 && oe_n[1] == 16 && oe_n[2] == 0 && extra_oe == 0,
        "R7 data only", extra_oe, 0);
    chk(got_w[1] == 16'hBEEF, "R7 adc word", int'(got_w[1]), 16'hBEEF);
    // R8
    chk(cont_mode == 1'b1 && dac_sample == 16'h1235, "R8 no exit without fmt",
        int'(cont_mode), 1);

    // continuous mode, format bit set
    do_reset();
    for (int s = 0; s < 6; s++) din_w[s] = 16'h0;
    din_w[4] = wr(1, 8'h41);
    run_frame(6, 0);
    din_w[1] = 16'h2468;
    run_frame(3, 0);
    repeat (4) @(negedge clk);
    chk(cont_mode == 1'b1, "R8 LSB0 stays", int'(cont_mode), 1);
    din_w[1] = 16'h0F0F;
    run_frame(3, 0);
    repeat (4) @(negedge clk);
    chk(cont_mode == 1'b0 && dac_sample == 16'h0F0F, "R8 LSB1 exits",
        int'(cont_mode), 0);
    for (int s = 0; s < 6; s++) din_w[s] = 16'h0;
    din_w[4] = rd(1);
    run_frame(6, 0);
    chk(oe_n[4] == 16, "R7 ctrl slot back", oe_n[4], 16);
    din_w[4] = 16'h0;
    run_frame(6, 0);
    chk(got_w[4] == 16'h0001, "R8 bit6 cleared", int'(got_w[4]), 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule